// File: doc/BRIEF.md
# Encoded Raster-Operation Expression Evaluator

This block evaluates one bitwise raster operation on three equal-width vectors: a source vector S, a destination vector D and a pattern vector P. The operation is not looked up in a truth table. It is rebuilt from the 16-bit low word of a raster-operation code. That word picks one of eight operand strings, rotates the string, and lists five two-bit logic operations plus a parity bit. The evaluator walks the rotated string from a computed start position toward position 1. It applies one operation per clock, using an accumulator and a one-entry stack for the strings that carry push and pop markers. A final inversion is applied when the parity bit is set.

A caller presents the code word and the three vectors and pulses `start` while the block is idle. The block captures all inputs, raises `busy`, and pulses `done` for one cycle when `result` is valid. `result` then holds until the next evaluation completes. The controller is a five-state machine:
- IDLE goes to LOAD on `start`.
- LOAD places the first operand in the accumulator and always goes to APPLY.
- APPLY executes one operation per cycle. A pop marker costs one extra APPLY cycle. After the fifth operation, APPLY goes to FINAL.
- FINAL applies the parity inversion and writes `result`, then goes to DONE.
- DONE asserts `done` and returns to IDLE.

Top module: `rop_expr_eval`

## Requirements
- R1: While reset is active and right after it is released, `busy`, `done` and `result` are all zero.
- R2: Code bits [7:6], [9:8], [11:10], [13:12] and [15:14] hold operations 1 to 5, applied in that order. Each operation is encoded as 00 = invert accumulator, 01 = XOR, 10 = OR, 11 = AND.
- R3: Code bits [4:2] select the operand string. Bits [1:0] rotate it left by that many symbols, so the symbol at 1-based position k after rotation is the one at position k+offset (mod 8) before it.
- R4: The first operand is the symbol at 1-based position (number of non-zero operation fields + 1) of the rotated string. Each binary operation takes the next lower position.
- R5: When the selected string holds push/pop markers, the start position is raised by 2. A binary operation that meets a pop marker first saves the accumulator to the stack, then reloads the accumulator from the next lower position, then applies the operation to the position below that. A binary operation that meets a push marker uses the saved stack value as its second operand.
- R6: Code bit [5] set inverts the final result. It is the only difference from the same code with bit [5] clear.
- R7: String 1 is fixed as S P D S P D S P and string 7 as S + S D - P D S, whatever the parameter table holds. Strings 0 and 2 to 6 come from the `STR_TAB` parameter, 3 bits per symbol: S=0, D=1, P=2, push(+)=3, pop(-)=4.
- R8: Code 0x1E05 yields NOT((((NOT P) OR S) AND D) XOR P). Code 0x1D5C yields NOT(((D XOR P) AND (D XOR S)) XOR S).
- R9: `done` is high for exactly one cycle. `result` changes only in the cycle in which `done` rises.
- R10: `start` is accepted only while idle. A `start` pulse, or any change of code or vectors, during an evaluation has no effect on that evaluation's result.
- R11: With `start` sampled high while idle in cycle 0, `done` is high in cycle 8 for strings without markers, and in cycle 9 for strings with markers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an evaluation (taken only when idle) |
| code | input | 16 | Low word of the raster-operation code |
| src_vec | input | WIDTH | Source operand S |
| dst_vec | input | WIDTH | Destination operand D |
| pat_vec | input | WIDTH | Pattern operand P |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle strobe: result valid |
| result | output | WIDTH | Evaluated vector, held between evaluations |

## Verification
The timing properties assume two things about the inputs. First, a pop marker is always followed by a plain operand. Second, a marker-bearing string is only used with exactly four binary operations, so the walk never runs below position 1 and each run crosses one pop at most. The stimulus stays inside these bounds: marker strings are driven only with offset 0, and every placement of one inverting operation among four binary ones is swept. Strings without markers are valid for any operation mix, so they are swept over all 1024 operation fields and across offsets and parity.

// File: rtl/rop_eval_pkg.sv
package rop_eval_pkg;

    localparam int CODE_W  = 16;
    localparam int SYM_W   = 3;
    localparam int STR_LEN = 8;
    localparam int STR_CNT = 8;
    localparam int STR_W   = SYM_W * STR_LEN;
    localparam int OP_W    = 2;
    localparam int N_OPS   = 5;
    localparam int IDX_W   = $clog2(STR_LEN);
    localparam int POS_W   = IDX_W + 1;
    localparam int CNT_W   = $clog2(N_OPS + 1);

    typedef enum logic [SYM_W-1:0] {
        SYM_S    = 3'd0,
        SYM_D    = 3'd1,
        SYM_P    = 3'd2,
        SYM_PUSH = 3'd3,
        SYM_POP  = 3'd4
    } sym_e;

    typedef enum logic [OP_W-1:0] {
        OP_NOT = 2'd0,
        OP_XOR = 2'd1,
        OP_OR  = 2'd2,
        OP_AND = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_APPLY,
        ST_FINAL,
        ST_DONE
    } state_e;

    // c0 is 1-based position 1 and sits in the least significant symbol slot
    function automatic logic [STR_W-1:0] pack_str(
        input sym_e c0, input sym_e c1, input sym_e c2, input sym_e c3,
        input sym_e c4, input sym_e c5, input sym_e c6, input sym_e c7);
        return {c7, c6, c5, c4, c3, c2, c1, c0};
    endfunction

    localparam logic [STR_W-1:0] STR_FIX1 =
        pack_str(SYM_S, SYM_P, SYM_D, SYM_S, SYM_P, SYM_D, SYM_S, SYM_P);
    localparam logic [STR_W-1:0] STR_FIX7 =
        pack_str(SYM_S, SYM_PUSH, SYM_S, SYM_D, SYM_POP, SYM_P, SYM_D, SYM_S);

    function automatic logic [STR_CNT*STR_W-1:0] default_table();
        return {
            STR_FIX7,
            pack_str(SYM_S, SYM_PUSH, SYM_S, SYM_P, SYM_POP, SYM_D, SYM_P, SYM_S),
            pack_str(SYM_D, SYM_P, SYM_S, SYM_D, SYM_P, SYM_S, SYM_D, SYM_P),
            pack_str(SYM_P, SYM_S, SYM_D, SYM_P, SYM_S, SYM_D, SYM_P, SYM_S),
            pack_str(SYM_D, SYM_S, SYM_P, SYM_D, SYM_S, SYM_P, SYM_D, SYM_S),
            pack_str(SYM_S, SYM_S, SYM_P, SYM_D, SYM_D, SYM_P, SYM_S, SYM_D),
            STR_FIX1,
            pack_str(SYM_S, SYM_D, SYM_P, SYM_S, SYM_D, SYM_P, SYM_S, SYM_D)
        };
    endfunction

endpackage

// File: rtl/rop_code_fields.sv
module rop_code_fields
    import rop_eval_pkg::*;
(
    input  logic [CODE_W-1:0]          code,
    output logic [1:0]                 rot,
    output logic [IDX_W-1:0]           sel,
    output logic                       inv,
    output logic [N_OPS-1:0][OP_W-1:0] ops,
    output logic [CNT_W-1:0]           nbin
);

    logic [N_OPS-1:0] is_bin;

    assign rot = code[1:0];
    assign sel = code[4:2];
    assign inv = code[5];

    for (genvar i = 0; i < N_OPS; i++) begin : g_op
        assign ops[i]    = code[6 + OP_W*i +: OP_W];
        assign is_bin[i] = (ops[i] != OP_NOT);
    end

    always_comb begin
        nbin = '0;
        for (int i = 0; i < N_OPS; i++) begin
            nbin = nbin + CNT_W'(is_bin[i]);
        end
    end

endmodule

// File: rtl/rop_str_select.sv
module rop_str_select
    import rop_eval_pkg::*;
#(
    parameter logic [STR_CNT*STR_W-1:0] STR_TAB = default_table()
) (
    input  logic [IDX_W-1:0] sel,
    input  logic [1:0]       rot,
    output logic [STR_W-1:0] str_rot,
    output logic             has_mark
);

    logic [STR_W-1:0]   chosen;
    logic [STR_LEN-1:0] mark;

    always_comb begin
        if (sel == IDX_W'(1)) begin
            chosen = STR_FIX1;
        end else if (sel == IDX_W'(7)) begin
            chosen = STR_FIX7;
        end else begin
            chosen = STR_TAB[sel*STR_W +: STR_W];
        end
    end

    for (genvar p = 0; p < STR_LEN; p++) begin : g_rot
        logic [IDX_W-1:0] src;
        assign src = IDX_W'(p) + IDX_W'(rot);
        assign str_rot[p*SYM_W +: SYM_W] = chosen[src*SYM_W +: SYM_W];
        assign mark[p] = (chosen[p*SYM_W +: SYM_W] == SYM_PUSH) ||
                         (chosen[p*SYM_W +: SYM_W] == SYM_POP);
    end

    assign has_mark = |mark;

endmodule

// File: rtl/rop_operand_pick.sv
module rop_operand_pick
    import rop_eval_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [SYM_W-1:0] sym,
    input  logic [WIDTH-1:0] s_vec,
    input  logic [WIDTH-1:0] d_vec,
    input  logic [WIDTH-1:0] p_vec,
    output logic [WIDTH-1:0] val
);

    always_comb begin
        case (sym)
            SYM_S:   val = s_vec;
            SYM_D:   val = d_vec;
            SYM_P:   val = p_vec;
            default: val = '0;
        endcase
    end

endmodule

// File: rtl/rop_expr_eval.sv
module rop_expr_eval
    import rop_eval_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter logic [STR_CNT*STR_W-1:0] STR_TAB = default_table()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    input  logic [WIDTH-1:0]  src_vec,
    input  logic [WIDTH-1:0]  dst_vec,
    input  logic [WIDTH-1:0]  pat_vec,
    output logic              busy,
    output logic              done,
    output logic [WIDTH-1:0]  result
);

    localparam int N_TAPS = 3;   // first operand, current position, position below it

    state_e state, state_nx;

    logic [CODE_W-1:0] code_q;
    logic [WIDTH-1:0]  s_q, d_q, p_q;
    logic [WIDTH-1:0]  acc, stk;
    logic [POS_W-1:0]  ptr;
    logic [CNT_W-1:0]  op_idx;

    logic [1:0]                 f_rot;
    logic [IDX_W-1:0]           f_sel;
    logic                       f_inv;
    logic [N_OPS-1:0][OP_W-1:0] f_ops;
    logic [CNT_W-1:0]           f_nbin;

    logic [STR_W-1:0] str_rot;
    logic             has_mark;
    logic [POS_W-1:0] start_pos;

    logic [IDX_W-1:0] tap_idx [N_TAPS];
    logic [SYM_W-1:0] tap_sym [N_TAPS];
    logic [WIDTH-1:0] tap_val [N_TAPS];

    logic [OP_W-1:0]  cur_op;
    logic             op_is_not;
    logic             hit_pop;
    logic             hit_push;
    logic             last_op;

    function automatic logic [WIDTH-1:0] combine(
        input logic [OP_W-1:0]  op,
        input logic [WIDTH-1:0] a,
        input logic [WIDTH-1:0] b);
        case (op)
            OP_XOR:  return a ^ b;
            OP_OR:   return a | b;
            OP_AND:  return a & b;
            default: return ~a;
        endcase
    endfunction

    rop_code_fields u_fields (
        .code (code_q),
        .rot  (f_rot),
        .sel  (f_sel),
        .inv  (f_inv),
        .ops  (f_ops),
        .nbin (f_nbin)
    );

    rop_str_select #(
        .STR_TAB (STR_TAB)
    ) u_select (
        .sel      (f_sel),
        .rot      (f_rot),
        .str_rot  (str_rot),
        .has_mark (has_mark)
    );

    assign start_pos = POS_W'(f_nbin) + POS_W'(1) + (has_mark ? POS_W'(2) : POS_W'(0));

    assign tap_idx[0] = IDX_W'(start_pos - POS_W'(1));
    assign tap_idx[1] = IDX_W'(ptr - POS_W'(1));
    assign tap_idx[2] = IDX_W'(ptr - POS_W'(2));

    for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
        assign tap_sym[t] = str_rot[tap_idx[t]*SYM_W +: SYM_W];
        rop_operand_pick #(
            .WIDTH (WIDTH)
        ) u_pick (
            .sym   (tap_sym[t]),
            .s_vec (s_q),
            .d_vec (d_q),
            .p_vec (p_q),
            .val   (tap_val[t])
        );
    end

    always_comb begin
        cur_op = f_ops[0];
        for (int i = 1; i < N_OPS; i++) begin
            if (op_idx == CNT_W'(i)) begin
                cur_op = f_ops[i];
            end
        end
    end

    assign op_is_not = (cur_op == OP_NOT);
    assign hit_pop   = !op_is_not && (tap_sym[1] == SYM_POP);
    assign hit_push  = !op_is_not && (tap_sym[1] == SYM_PUSH);
    assign last_op   = (op_idx == CNT_W'(N_OPS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_LOAD;
            ST_LOAD:  state_nx = ST_APPLY;
            ST_APPLY: if (!hit_pop && last_op) state_nx = ST_FINAL;
            ST_FINAL: state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            s_q    <= '0;
            d_q    <= '0;
            p_q    <= '0;
            acc    <= '0;
            stk    <= '0;
            ptr    <= '0;
            op_idx <= '0;
            result <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        code_q <= code;
                        s_q    <= src_vec;
                        d_q    <= dst_vec;
                        p_q    <= pat_vec;
                    end
                end
                ST_LOAD: begin
                    acc    <= tap_val[0];
                    ptr    <= start_pos - POS_W'(1);
                    op_idx <= '0;
                end
                ST_APPLY: begin
                    if (op_is_not) begin
                        acc    <= ~acc;
                        op_idx <= op_idx + CNT_W'(1);
                    end else if (hit_pop) begin
                        stk <= acc;
                        acc <= tap_val[2];
                        ptr <= ptr - POS_W'(2);
                    end else if (hit_push) begin
                        acc    <= combine(cur_op, acc, stk);
                        ptr    <= ptr - POS_W'(1);
                        op_idx <= op_idx + CNT_W'(1);
                    end else begin
                        acc    <= combine(cur_op, acc, tap_val[1]);
                        ptr    <= ptr - POS_W'(1);
                        op_idx <= op_idx + CNT_W'(1);
                    end
                end
                ST_FINAL: begin
                    result <= f_inv ? ~acc : acc;
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy = (state == ST_LOAD) || (state == ST_APPLY) || (state == ST_FINAL);
        done = (state == ST_DONE);
    end

endmodule

// File: rtl/rop_expr_eval_chk.sv
module rop_expr_eval_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] result
);

    logic [3:0] run_cnt;

    // cycles since an accepted start, seen only from the ports
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (start && !busy && !done) begin
            run_cnt <= 4'd1;
        end else if (done) begin
            run_cnt <= '0;
        end else if (run_cnt != 4'd0 && run_cnt != 4'd15) begin
            run_cnt <= run_cnt + 4'd1;
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_accept_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == 4'd8 || run_cnt == 4'd9));

endmodule

bind rop_expr_eval rop_expr_eval_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/sim_rop_expr_eval.sv
module sim_rop_expr_eval;
    import rop_eval_pkg::*;

    localparam int W = 8;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 190000;

    // bench table: slots 1 and 7 hold junk that the block must ignore (R7)
    localparam logic [STR_CNT*STR_W-1:0] TB_TAB = {
        pack_str(SYM_S, SYM_S, SYM_S, SYM_S, SYM_S, SYM_S, SYM_S, SYM_S),
        pack_str(SYM_P, SYM_PUSH, SYM_P, SYM_S, SYM_POP, SYM_D, SYM_S, SYM_D),
        pack_str(SYM_D, SYM_P, SYM_S, SYM_P, SYM_S, SYM_D, SYM_D, SYM_S),
        pack_str(SYM_P, SYM_D, SYM_S, SYM_S, SYM_P, SYM_D, SYM_D, SYM_P),
        pack_str(SYM_S, SYM_S, SYM_D, SYM_D, SYM_P, SYM_P, SYM_S, SYM_D),
        pack_str(SYM_P, SYM_P, SYM_S, SYM_D, SYM_S, SYM_P, SYM_D, SYM_D),
        pack_str(SYM_D, SYM_D, SYM_D, SYM_D, SYM_D, SYM_D, SYM_D, SYM_D),
        pack_str(SYM_D, SYM_S, SYM_P, SYM_D, SYM_S, SYM_P, SYM_D, SYM_S)
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [15:0]   code_i = '0;
    logic [W-1:0]  src_i = '0, dst_i = '0, pat_i = '0;
    logic          busy_o, done_o;
    logic [W-1:0]  result_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] seed = 32'h1234_5678;

    rop_expr_eval #(
        .WIDTH   (W),
        .STR_TAB (TB_TAB)
    ) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .code    (code_i),
        .src_vec (src_i),
        .dst_vec (dst_i),
        .pat_vec (pat_i),
        .busy    (busy_o),
        .done    (done_o),
        .result  (result_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG) begin
            errors++;
            $display("FAIL watchdog expired actual %0d expected below %0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rnd(output logic [W-1:0] v);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        v = seed[W-1:0];
    endtask

    function automatic logic [STR_W-1:0] str_of(input logic [2:0] sel);
        if (sel == 3'd1) return pack_str(SYM_S, SYM_P, SYM_D, SYM_S, SYM_P, SYM_D, SYM_S, SYM_P);
        if (sel == 3'd7) return pack_str(SYM_S, SYM_PUSH, SYM_S, SYM_D, SYM_POP, SYM_P, SYM_D, SYM_S);
        return TB_TAB[sel*STR_W +: STR_W];
    endfunction

    function automatic bit marked(input logic [2:0] sel);
        logic [STR_W-1:0] st;
        st = str_of(sel);
        for (int i = 0; i < 8; i++) begin
            if (st[i*3 +: 3] == 3'd3 || st[i*3 +: 3] == 3'd4) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic logic [W-1:0] sym_val(input logic [2:0] y, input logic [W-1:0] s, d, p);
        case (y)
            3'd0: return s;
            3'd1: return d;
            3'd2: return p;
            default: return '0;
        endcase
    endfunction

    function automatic logic [W-1:0] ref_eval(input logic [15:0] c, input logic [W-1:0] s, d, p);
        logic [STR_W-1:0] st;
        logic [2:0] r [8];
        logic [W-1:0] acc, stk, b;
        logic [1:0] op;
        int nb, pos;
        st = str_of(c[4:2]);
        for (int i = 0; i < 8; i++) r[i] = st[((i + c[1:0]) % 8)*3 +: 3];
        nb = 0;
        for (int k = 0; k < 5; k++) if (c[6+2*k +: 2] != 2'd0) nb++;
        pos = nb + 1 + (marked(c[4:2]) ? 2 : 0);
        acc = sym_val(r[pos-1], s, d, p);
        pos--;
        stk = '0;
        for (int k = 0; k < 5; k++) begin
            op = c[6+2*k +: 2];
            if (op == 2'd0) begin
                acc = ~acc;
            end else begin
                if (pos >= 2 && r[pos-1] == 3'd4) begin
                    stk = acc;
                    acc = sym_val(r[pos-2], s, d, p);
                    pos -= 2;
                end
                if (pos >= 1 && r[pos-1] == 3'd3) b = stk;
                else if (pos >= 1) b = sym_val(r[pos-1], s, d, p);
                else b = '0;
                case (op)
                    2'd1: acc = acc ^ b;
                    2'd2: acc = acc | b;
                    default: acc = acc & b;
                endcase
                pos--;
            end
        end
        if (c[5]) acc = ~acc;
        return acc;
    endfunction

    task automatic run_code(input logic [15:0] c, input logic [W-1:0] s, d, p,
                            input string tag, input bit intrude);
        logic [W-1:0] exp;
        int k, want;
        bit seen;
        exp  = ref_eval(c, s, d, p);
        want = marked(c[4:2]) ? 9 : 8;
        code_i = c; src_i = s; dst_i = d; pat_i = p; start_i = 1'b1;
        k = 0; seen = 0;
        while (!seen && k < 20) begin
            @(negedge clk);
            k++;
            if (k == 1) start_i = 1'b0;
            if (intrude && k == 3) begin
                check(busy_o == 1'b1, "R10 busy mid-run", busy_o, 1);
                start_i = 1'b1; code_i = ~c; src_i = ~s; dst_i = ~d; pat_i = ~p;
            end
            if (intrude && k == 4) start_i = 1'b0;
            if (done_o) seen = 1;
        end
        if (!seen) begin
            check(1'b0, {tag, " timeout"}, k, want);
        end else begin
            check(result_o == exp, tag, result_o, exp);
            check(k == want, "R11 latency", k, want);
            @(negedge clk);
            check(!done_o, "R9 done one cycle", done_o, 0);
            check(result_o == exp, "R9 result held", result_o, exp);
        end
    endtask

    task automatic run_rand(input logic [15:0] c, input string tag);
        logic [W-1:0] s, d, p;
        rnd(s); rnd(d); rnd(p);
        run_code(c, s, d, p, tag, 1'b0);
    endtask

    initial begin
        logic [W-1:0] s, d, p, r0;
        logic [2:0] sels [5] = '{3'd0, 3'd2, 3'd3, 3'd4, 3'd5};

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && result_o == '0, "R1 in reset", {busy_o, done_o, result_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && result_o == '0, "R1 after reset", {busy_o, done_o, result_o}, 0);

        // R2: every operation field value on string 1, offset 1
        for (int o = 0; o < 1024; o++) run_rand({o[9:0], 1'b0, 3'd1, 2'd1}, "R2 op sweep");

        // R4: start position over all operation counts, strings 0 and 2, no rotation
        for (int o = 0; o < 1024; o++) begin
            run_rand({o[9:0], 1'b0, 3'd0, 2'd0}, "R4 start position");
            run_rand({o[9:0], 1'b0, 3'd2, 2'd0}, "R4 start position");
        end

        // R3: rotation across table strings, offsets and parity
        for (int si = 0; si < 5; si++)
            for (int off = 0; off < 4; off++)
                for (int par = 0; par < 2; par++)
                    for (int j = 0; j < 16; j++) begin
                        int o;
                        o = (j * 67 + 5) % 1024;
                        run_rand({o[9:0], par[0], sels[si], off[1:0]}, "R3 rotation");
                    end

        // R5: marker strings, one NOT placed anywhere among four binary ops
        for (int sl = 6; sl < 8; sl++)
            for (int par = 0; par < 2; par++)
                for (int np = 0; np < 5; np++)
                    for (int cmb = 0; cmb < 81; cmb++) begin
                        logic [9:0] ops;
                        int v, bi;
                        v = cmb; bi = 0; ops = '0;
                        for (int slot = 0; slot < 5; slot++) begin
                            if (slot != np) begin
                                ops[2*slot +: 2] = 2'((v % 3) + 1);
                                v = v / 3;
                                bi++;
                            end
                        end
                        run_rand({ops, par[0], sl[2:0], 2'd0}, "R5 push pop");
                    end

        // R6: parity bit complements the result and changes nothing else
        for (int j = 0; j < 32; j++) begin
            logic [15:0] c;
            c = {10'((j * 151 + 3) % 1024), 1'b0, (j % 2 == 0) ? 3'd1 : sels[j % 5], 2'(j % 4)};
            rnd(s); rnd(d); rnd(p);
            run_code(c, s, d, p, "R6 parity clear", 1'b0);
            r0 = result_o;
            run_code(c | 16'h0020, s, d, p, "R6 parity set", 1'b0);
            check(result_o == ~r0, "R6 complement", result_o, ~r0);
        end

        // R7 and R8: fixed strings and the two check vectors
        for (int j = 0; j < 16; j++) begin
            logic [W-1:0] e;
            rnd(s); rnd(d); rnd(p);
            run_code(16'h1E05, s, d, p, "R7 fixed string 1", 1'b0);
            e = ~((((~p) | s) & d) ^ p);
            check(result_o == e, "R8 vector 1E05", result_o, e);
            run_code(16'h1D5C, s, d, p, "R7 fixed string 7", 1'b0);
            e = ~(((d ^ p) & (d ^ s)) ^ s);
            check(result_o == e, "R8 vector 1D5C", result_o, e);
        end

        // R10: start and input changes during a run are ignored
        for (int j = 0; j < 32; j++) begin
            logic [15:0] c;
            c = (j % 4 == 0) ? 16'h1D5C : {10'((j * 97 + 11) % 1024), j[0], sels[j % 5], 2'(j % 4)};
            rnd(s); rnd(d); rnd(p);
            run_code(c, s, d, p, "R10 ignore start", 1'b1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule